// File: doc/BRIEF.md
# Zero-Suppressing Decimal Display Controller

This block takes an eight-digit decimal number, presented as eight 4-bit BCD digits in parallel, and produces for every digit a blank flag and an active-low seven-segment pattern. A fixed decimal point sits between the integer field (the upper digits) and the fraction field (the lower digits). Leading zeros of the integer field and trailing zeros of the fraction field are blanked, so that a value such as 0060.0300 appears as 60.03. The digit on each side of the point is always shown.

Two ripple-blank chains do the suppression. The integer chain starts at the most significant digit with its blank input held active and passes each digit's blank state down to the next less significant digit. The fraction chain starts at the least significant digit and runs upward toward the point. Both chains are combinational. Each chain ends at the digit next to the point, whose blank input is tied inactive. The results pass through one register stage with a valid/ready handshake on both sides.

Digits are numbered 7 (most significant) down to 0; `in_digits[4*i+3:4*i]` is digit i. The split is set by `INT_DIGITS` (default 4), and the number of fraction digits is `NUM_DIGITS - INT_DIGITS`. The input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is not taken stays unchanged on the outputs until `out_ready` rises.

Top module: `zsup_display`

## Requirements
- R1: Starting from digit 7, each integer digit that is zero is blanked as long as every more significant digit is blanked. The first nonzero integer digit stops the blanking.
- R2: The least significant integer digit (digit 4 by default) is never blanked, even if every integer digit is zero.
- R3: Starting from digit 0, each fraction digit that is zero is blanked as long as every less significant digit is blanked. The first nonzero fraction digit stops the blanking.
- R4: The most significant fraction digit (digit 3 by default) is never blanked, so 0005.0000 shows as 5.0 (blank flags 8'b1110_0111).
- R5: Codes 10 to 15 count as nonzero. They stop a chain and are never blanked. Code 15 has no lit segments but its blank flag is 0.
- R6: An unblanked digit drives `out_seg_n[7*i+6:7*i]` with bit 0 = segment a through bit 6 = segment g, active low. As hex of the lit segments, codes 0..15 are 3F 06 5B 4F 66 6D 7D 07 7F 6F 40 79 76 38 73 00.
- R7: A digit whose blank flag is set drives all seven segment bits high (7'h7F).
- R8: A word accepted on a clock edge appears with `out_valid` high after that edge, one cycle of latency, in acceptance order.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_blank` and `out_seg_n` keep their values.
- R10: During reset `out_valid` is low and `in_ready` is high.
- R11: When the output is taken and no new word is accepted on the same edge, `out_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_digits | input | 4*NUM_DIGITS | BCD digits, digit i in bits 4i+3..4i |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_blank | output | NUM_DIGITS | Per-digit blank flag, 1 = suppressed |
| out_seg_n | output | 7*NUM_DIGITS | Active-low segments, digit i in bits 7i+6..7i |

## Verification
The handshake assertions assume that the consumer drives `out_ready` to a known level in every cycle. They also assume that `in_valid`, once raised, holds its word until it is accepted. The bench keeps to this by changing a word only after the cycle in which `in_ready` was sampled high. The stimulus draws digits heavily toward zero so that long chains of suppressed digits occur, and it injects codes 10 to 15 to break those chains. Random stalls on `out_ready` exercise the hold behaviour, and directed words cover all zeros, all nonzero digits and zeros on both sides of the point.

// File: rtl/zsup_pkg.sv
`timescale 1ns/1ps
package zsup_pkg;
  localparam int SEG_W   = 7;
  localparam int DIGIT_W = 4;

  // Lit segments (active high), bit 0 = a .. bit 6 = g.
  function automatic logic [SEG_W-1:0] seg_lit(input logic [DIGIT_W-1:0] code);
    logic [SEG_W-1:0] s;
    case (code)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      4'd10:   s = 7'h40;
      4'd11:   s = 7'h79;
      4'd12:   s = 7'h76;
      4'd13:   s = 7'h38;
      4'd14:   s = 7'h73;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/zsup_chain.sv
`timescale 1ns/1ps
// Ripple-blank chain. Chain position LEN-1 is the start (blank input
// forced active); position 0 is the end (blank input forced inactive).
module zsup_chain #(
  parameter int LEN = 4
) (
  input  logic [LEN*zsup_pkg::DIGIT_W-1:0] digits_i,
  output logic [LEN-1:0]                   blank_o
);
  import zsup_pkg::*;

  for (genvar k = 0; k < LEN; k++) begin : g_link
    logic rb_in;
    logic is_zero;
    assign is_zero = (digits_i[k*DIGIT_W +: DIGIT_W] == '0);
    if (k == 0) begin : g_end
      assign rb_in = 1'b0;
    end else if (k == LEN-1) begin : g_start
      assign rb_in = 1'b1;
    end else begin : g_mid
      assign rb_in = blank_o[k+1];
    end
    assign blank_o[k] = rb_in & is_zero;
  end
endmodule

// File: rtl/zsup_seg_dec.sv
`timescale 1ns/1ps
module zsup_seg_dec (
  input  logic [zsup_pkg::DIGIT_W-1:0] code_i,
  input  logic                         blank_i,
  output logic [zsup_pkg::SEG_W-1:0]   seg_n_o
);
  import zsup_pkg::*;
  always_comb begin
    if (blank_i) seg_n_o = '1;
    else         seg_n_o = ~seg_lit(code_i);
  end
endmodule

// File: rtl/zsup_display.sv
`timescale 1ns/1ps
module zsup_display #(
  parameter int NUM_DIGITS = 8,
  parameter int INT_DIGITS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [4*NUM_DIGITS-1:0]   in_digits,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [NUM_DIGITS-1:0]     out_blank,
  output logic [7*NUM_DIGITS-1:0]  out_seg_n
);
  import zsup_pkg::*;

  localparam int FRAC_DIGITS = NUM_DIGITS - INT_DIGITS;
  localparam int DW          = DIGIT_W;

  logic [NUM_DIGITS-1:0]       blank_c;
  logic [SEG_W*NUM_DIGITS-1:0] seg_c;
  logic [INT_DIGITS-1:0]       int_blank;
  logic [FRAC_DIGITS*DW-1:0]   frac_rev;
  logic [FRAC_DIGITS-1:0]      frac_blank;

  // Integer field: chain start is the most significant digit.
  zsup_chain #(.LEN(INT_DIGITS)) u_int_chain (
    .digits_i (in_digits[NUM_DIGITS*DW-1 : FRAC_DIGITS*DW]),
    .blank_o  (int_blank)
  );
  assign blank_c[NUM_DIGITS-1:FRAC_DIGITS] = int_blank;

  // Fraction field: chain start is digit 0, so reverse the order.
  for (genvar k = 0; k < FRAC_DIGITS; k++) begin : g_frac_map
    assign frac_rev[k*DW +: DW]       = in_digits[(FRAC_DIGITS-1-k)*DW +: DW];
    assign blank_c[FRAC_DIGITS-1-k]   = frac_blank[k];
  end

  zsup_chain #(.LEN(FRAC_DIGITS)) u_frac_chain (
    .digits_i (frac_rev),
    .blank_o  (frac_blank)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
    zsup_seg_dec u_dec (
      .code_i  (in_digits[i*DW +: DW]),
      .blank_i (blank_c[i]),
      .seg_n_o (seg_c[i*SEG_W +: SEG_W])
    );
  end

  // Single output stage with valid/ready.
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_blank <= '1;
      out_seg_n <= '1;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_blank <= blank_c;
        out_seg_n <= seg_c;
      end
    end
  end
endmodule

// File: rtl/zsup_display_chk.sv
`timescale 1ns/1ps
module zsup_display_chk #(
  parameter int NUM_DIGITS = 8,
  parameter int INT_DIGITS = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [4*NUM_DIGITS-1:0]  in_digits,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [NUM_DIGITS-1:0]    out_blank,
  input logic [7*NUM_DIGITS-1:0]  out_seg_n
);
  localparam int FRAC_DIGITS = NUM_DIGITS - INT_DIGITS;

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_blank) && $stable(out_seg_n));

  assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_accept_shows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  assert_int_edge_shown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_blank[FRAC_DIGITS]);

  assert_frac_edge_shown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_blank[FRAC_DIGITS-1]);

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    assert_blank_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_blank[i] |-> out_seg_n[7*i +: 7] == 7'h7F);
  end
  for (genvar i = FRAC_DIGITS+1; i < NUM_DIGITS; i++) begin : g_int
    assert_int_ripple_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_blank[i-1] |-> out_blank[i]);
  end
  for (genvar i = 0; i + 1 < FRAC_DIGITS; i++) begin : g_frac
    assert_frac_ripple_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_blank[i+1] |-> out_blank[i]);
  end
endmodule

bind zsup_display zsup_display_chk #(
  .NUM_DIGITS (NUM_DIGITS),
  .INT_DIGITS (INT_DIGITS)
) u_chk (.*);

// File: tb/zsup_display_bench.sv
`timescale 1ns/1ps
module zsup_display_bench;
  localparam int ND = 8;
  localparam int NI = 4;
  localparam int NF = ND - NI;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [4*ND-1:0] in_digits = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [ND-1:0]   out_blank;
  logic [7*ND-1:0] out_seg_n;

  zsup_display #(.NUM_DIGITS(ND), .INT_DIGITS(NI)) u_zsup_display (.*);

  logic [4*ND-1:0] q_exp[$];
  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  int stall_pct = 0;
  bit done  = 1'b0;

  // Blank flags from the requirement text (R1..R5).
  function automatic logic [ND-1:0] ref_blank(input logic [4*ND-1:0] d);
    logic [ND-1:0] b = '0;
    for (int i = ND-1; i > NF; i--) begin
      if (d[4*i +: 4] != 4'd0) break;
      b[i] = 1'b1;
    end
    for (int j = 0; j < NF-1; j++) begin
      if (d[4*j +: 4] != 4'd0) break;
      b[j] = 1'b1;
    end
    return b;
  endfunction

  function automatic logic [6:0] ref_lit(input logic [3:0] c);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h40, 7'h79, 7'h76, 7'h38, 7'h73, 7'h00};
    return t[c];
  endfunction

  function automatic logic [7*ND-1:0] ref_seg(input logic [4*ND-1:0] d);
    logic [ND-1:0]   b = ref_blank(d);
    logic [7*ND-1:0] s;
    for (int i = 0; i < ND; i++)
      s[7*i +: 7] = b[i] ? 7'h7F : ~ref_lit(d[4*i +: 4]);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // Reference comparison on every clock, away from the edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 R10 in_ready", 64'(in_ready), 64'(!out_valid || out_ready));
      if (out_valid) begin
        if (q_exp.size() == 0) begin
          chk("R8 unexpected out_valid", 64'(out_valid), 64'd0);
        end else begin
          chk("R1 R2 R3 R4 R5 blank flags", 64'(out_blank), 64'(ref_blank(q_exp[0])));
          chk("R6 R7 segments lo", 64'(out_seg_n[31:0]), 64'(ref_seg(q_exp[0]) >> 0) & 64'hFFFF_FFFF);
          chk("R6 R7 segments hi", 64'(out_seg_n[7*ND-1:32]), 64'(ref_seg(q_exp[0]) >> 32));
          if (out_ready) void'(q_exp.pop_front());
        end
      end else begin
        chk("R8 R11 nothing pending", 64'(q_exp.size()), 64'd0);
      end
      if (in_valid && in_ready) q_exp.push_back(in_digits);
    end
  end

  // Consumer: random back-pressure.
  always @(posedge clk) begin
    #1;
    if (!done) out_ready <= (($urandom % 100) >= stall_pct);
  end

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      summary();
    end
  end

  task automatic send(input logic [4*ND-1:0] d);
    bit fire;
    in_valid  = 1'b1;
    in_digits = d;
    do begin
      @(negedge clk);
      fire = in_ready;
      @(posedge clk);
      #1;
    end while (!fire);
    in_valid = 1'b0;
  endtask

  function automatic logic [4*ND-1:0] rnd_word();
    logic [4*ND-1:0] w;
    for (int i = 0; i < ND; i++) begin
      int r = $urandom % 8;
      w[4*i +: 4] = (r < 4) ? 4'd0 : (r < 7) ? 4'(1 + $urandom % 9) : 4'($urandom % 16);
    end
    return w;
  endfunction

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk("R10 reset out_valid", 64'(out_valid), 64'd0);
      chk("R10 reset in_ready", 64'(in_ready), 64'd1);
    end
    @(posedge clk);
    #1 rst_n = 1'b1;

    stall_pct = 0;
    send(32'h0060_0300);   // R1 R3 -> 60.03
    send(32'h0000_0000);   // R2 R4 all zeros -> 0.0
    send(32'h0005_0000);   // R4 -> 5.0
    send(32'h1234_5678);   // no suppression
    send(32'h9999_9999);
    send(32'h0A00_00B0);   // R5 codes break chains
    send(32'hF000_000F);   // R5 code 15 not blanked
    send(32'h0000_0001);
    send(32'h1000_0000);
    send(32'h00C0_0E00);
    for (int c = 0; c < 16; c++) send({8{4'(c)}});  // R6 every code

    stall_pct = 40;
    for (int n = 0; n < 1500; n++) begin
      send(rnd_word());
      if (($urandom % 5) == 0) begin
        @(posedge clk);
        #1;
      end
    end

    stall_pct = 0;
    repeat (6) @(posedge clk);
    done = 1'b1;
    chk("R11 drained", 64'(q_exp.size()), 64'd0);
    summary();
  end
endmodule